// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of a conditional branch by running two predictors side by side and letting a per-address chooser decide which one to trust. The global predictor indexes 2-bit saturating counters with a shift register of recent resolved outcomes. The local predictor has two levels. A table of per-address history words is indexed by the low address bits. The word it returns indexes a table of 3-bit saturating counters. A third table of 2-bit counters, indexed by the branch address, picks the component whose answer becomes the final prediction.

A lookup presents an address index. One cycle later the block returns the final direction, which component was chosen, both component directions, and the global and local history values that were used. The fetch pipeline keeps that metadata with the branch. When the branch resolves, the pipeline hands the metadata back together with the real outcome. All three tables are then trained at the captured indices, and the global history register and the local history entry shift in the outcome. Table sizes are parameters.

Top module: `tourney_bp`

## Requirements
- R1: After reset `pred_valid` is 0. Every global counter resets to 1 and every local counter resets to 3, so both mean weakly not taken. Every chooser entry resets to 1, weakly favouring the global component. The global history and all local history words reset to 0.
- R2: The outputs are registered. `pred_valid` is high exactly one cycle after `lookup_valid`. A lookup sees the table state from before any update applied on the same clock edge.
- R3: A global counter is 2 bits wide and is indexed by the global history register. Its bit 1 gives the global direction. On update it moves toward the outcome and saturates at 0 and 3.
- R4: Each update shifts the resolved outcome into bit 0 of the global history register, and the older bits move up one place.
- R5: The local history word selected by the low `LT_W` bits of the update address shifts the outcome into its bit 0.
- R6: A local counter is 3 bits wide and is indexed by a local history word. Its bit 2 gives the local direction. It moves toward the outcome and saturates at 0 and 7.
- R7: The chooser entry is indexed by the full `IDX_W`-bit address. Values 0 and 1 select the global component, and values 2 and 3 select the local component. `pred_use_local` reports the selection.
- R8: The chooser increments, saturating at 3, when only the local component was right. It decrements, saturating at 0, when only the global component was right.
- R9: The chooser does not change when both components were right or both were wrong.
- R10: An update trains the counters at the returned `upd_ghist` and `upd_lhist` indices, not at the current histories.
- R11: `pred_taken` equals the direction of the component that the chooser selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Lookup request |
| lookup_idx | input | IDX_W | Branch address bits for the lookup |
| upd_valid | input | 1 | Resolved branch update |
| upd_idx | input | IDX_W | Branch address bits of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_ghist | input | GH_W | Global history returned from the prediction |
| upd_lhist | input | LH_W | Local history returned from the prediction |
| upd_gtaken | input | 1 | Global component direction returned from the prediction |
| upd_ltaken | input | 1 | Local component direction returned from the prediction |
| pred_valid | output | 1 | Prediction outputs are valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_use_local | output | 1 | Chooser selected the local component |
| pred_gtaken | output | 1 | Global component direction |
| pred_ltaken | output | 1 | Local component direction |
| pred_ghist | output | GH_W | Global history used for this lookup |
| pred_lhist | output | LH_W | Local history used for this lookup |

## Verification
The bench drives updates with forced component verdicts. This walks the chooser across its switching threshold, into saturation and back, and holds it on both-right and both-wrong verdicts. A chooser that moved on agreement, or that wrapped instead of saturating, would flip `pred_use_local` where it should not. In one test, a stale prediction's metadata is returned after other updates have already moved the histories. A design that trained at the live history would then drift from the reference on later lookups. A lookup and an update share one edge in another test, which catches a design that forwards the fresh update into the prediction. Long biased training runs drive the 3-bit and 2-bit counters into both saturation limits.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // Chooser counter levels: the upper half selects the local component
  localparam logic [1:0] CHOOSE_RST = 2'd1;

  function automatic logic choose_local(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  // Verdict of one resolved branch for the chooser
  typedef enum logic [1:0] {
    VERD_AGREE      = 2'd0,
    VERD_LOCAL_WINS = 2'd1,
    VERD_GLOBAL_WINS = 2'd2
  } verdict_e;

  function automatic verdict_e judge(input logic outcome, input logic g_dir,
                                     input logic l_dir);
    logic g_ok, l_ok;
    g_ok = (g_dir == outcome);
    l_ok = (l_dir == outcome);
    if (l_ok && !g_ok) return VERD_LOCAL_WINS;
    if (g_ok && !l_ok) return VERD_GLOBAL_WINS;
    return VERD_AGREE;
  endfunction
endpackage

// File: rtl/tbp_sat_table.sv
module tbp_sat_table #(
  parameter int IDX_W   = 6,
  parameter int CW      = 2,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CW-1:0]    rd_val,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_inc
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CRST = CW'(RST_VAL);

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] cur;

  assign cur    = mem[up_idx];
  assign rd_val = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CRST;
    end else if (up_en) begin
      if (up_inc && cur != CMAX) mem[up_idx] <= cur + 1'b1;
      else if (!up_inc && cur != '0) mem[up_idx] <= cur - 1'b1;
    end
  end

  // R3 R6 R8: counters stick at their ceiling
  p_sat_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    (up_en && up_inc && cur == CMAX) |=> mem[$past(up_idx)] == CMAX);
  // R3 R6 R8: counters stick at their floor
  p_sat_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (up_en && !up_inc && cur == '0) |=> mem[$past(up_idx)] == '0);
  // R9: without an update enable no entry moves
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !up_en |=> mem[$past(rd_idx)] == $past(rd_val));
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W = 4,
  parameter int HW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [HW-1:0]    rd_hist,
  input  logic             sh_en,
  input  logic [IDX_W-1:0] sh_idx,
  input  logic             sh_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HW-1:0] mem [DEPTH];

  assign rd_hist = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (sh_en) begin
      mem[sh_idx] <= {mem[sh_idx][HW-2:0], sh_bit};
    end
  end

  // R5: newest outcome lands in bit 0 of the addressed word
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
    sh_en |=> mem[$past(sh_idx)][0] == $past(sh_bit));
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int IDX_W = 6,
  parameter int GH_W  = 6,
  parameter int LT_W  = 4,
  parameter int LH_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_valid,
  input  logic [IDX_W-1:0] lookup_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  logic [GH_W-1:0]  upd_ghist,
  input  logic [LH_W-1:0]  upd_lhist,
  input  logic             upd_gtaken,
  input  logic             upd_ltaken,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic             pred_use_local,
  output logic             pred_gtaken,
  output logic             pred_ltaken,
  output logic [GH_W-1:0]  pred_ghist,
  output logic [LH_W-1:0]  pred_lhist
);
  import tbp_pkg::*;

  localparam int GC_W = 2;
  localparam int LC_W = 3;
  localparam int LC_RST = (1 << (LC_W - 1)) - 1;
  localparam int GC_RST = (1 << (GC_W - 1)) - 1;

  logic [GH_W-1:0] ghr;
  logic [LH_W-1:0] rd_lhist;
  logic [GC_W-1:0] rd_gc;
  logic [LC_W-1:0] rd_lc;
  logic [1:0]      rd_ch;
  verdict_e        verdict;
  logic            ch_en;
  logic            use_loc;

  assign verdict = judge(upd_taken, upd_gtaken, upd_ltaken);
  assign ch_en   = upd_valid && (verdict != VERD_AGREE);
  assign use_loc = choose_local(rd_ch);

  tbp_sat_table #(.IDX_W(GH_W), .CW(GC_W), .RST_VAL(GC_RST)) u_gctr (
    .clk, .rst, .rd_idx(ghr), .rd_val(rd_gc),
    .up_en(upd_valid), .up_idx(upd_ghist), .up_inc(upd_taken));

  tbp_hist_table #(.IDX_W(LT_W), .HW(LH_W)) u_lhist (
    .clk, .rst, .rd_idx(lookup_idx[LT_W-1:0]), .rd_hist(rd_lhist),
    .sh_en(upd_valid), .sh_idx(upd_idx[LT_W-1:0]), .sh_bit(upd_taken));

  tbp_sat_table #(.IDX_W(LH_W), .CW(LC_W), .RST_VAL(LC_RST)) u_lctr (
    .clk, .rst, .rd_idx(rd_lhist), .rd_val(rd_lc),
    .up_en(upd_valid), .up_idx(upd_lhist), .up_inc(upd_taken));

  tbp_sat_table #(.IDX_W(IDX_W), .CW(2), .RST_VAL(int'(CHOOSE_RST))) u_chooser (
    .clk, .rst, .rd_idx(lookup_idx), .rd_val(rd_ch),
    .up_en(ch_en), .up_idx(upd_idx), .up_inc(verdict == VERD_LOCAL_WINS));

  always_ff @(posedge clk) begin
    if (rst) ghr <= '0;
    else if (upd_valid) ghr <= {ghr[GH_W-2:0], upd_taken};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid     <= 1'b0;
      pred_taken     <= 1'b0;
      pred_use_local <= 1'b0;
      pred_gtaken    <= 1'b0;
      pred_ltaken    <= 1'b0;
      pred_ghist     <= '0;
      pred_lhist     <= '0;
    end else begin
      pred_valid <= lookup_valid;
      if (lookup_valid) begin
        pred_gtaken    <= rd_gc[GC_W-1];
        pred_ltaken    <= rd_lc[LC_W-1];
        pred_use_local <= use_loc;
        pred_taken     <= use_loc ? rd_lc[LC_W-1] : rd_gc[GC_W-1];
        pred_ghist     <= ghr;
        pred_lhist     <= rd_lhist;
      end
    end
  end

  // R2: one-cycle registered response
  p_resp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> pred_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !pred_valid);
  // R4: global history shifts the outcome in at bit 0
  p_ghr_shift_r4: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (ghr[0] == $past(upd_taken)) &&
                  (ghr[GH_W-1:1] == $past(ghr[GH_W-2:0])));
  // R4: global history holds without an update
  p_ghr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghr));
endmodule

// File: tb/tourney_bp_tb.sv
module tourney_bp_tb;
  localparam int IDX_W = 6, GH_W = 6, LT_W = 4, LH_W = 6;

  logic clk = 0, rst = 1;
  logic lookup_valid = 0, upd_valid = 0, upd_taken = 0, upd_gtaken = 0, upd_ltaken = 0;
  logic [IDX_W-1:0] lookup_idx = '0, upd_idx = '0;
  logic [GH_W-1:0] upd_ghist = '0;
  logic [LH_W-1:0] upd_lhist = '0;
  logic pred_valid, pred_taken, pred_use_local, pred_gtaken, pred_ltaken;
  logic [GH_W-1:0] pred_ghist;
  logic [LH_W-1:0] pred_lhist;

  always #10 clk = ~clk;

  tourney_bp #(.IDX_W(IDX_W), .GH_W(GH_W), .LT_W(LT_W), .LH_W(LH_W)) u_dut (.*);

  typedef struct {
    logic tk, ul, gt, lt;
    logic [GH_W-1:0] gh;
    logic [LH_W-1:0] lh;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [1:0] m_g [1 << GH_W];
  logic [2:0] m_l [1 << LH_W];
  logic [1:0] m_ch [1 << IDX_W];
  logic [LH_W-1:0] m_lht [1 << LT_W];
  logic [GH_W-1:0] m_ghr;

  // last observed metadata
  logic l_gt, l_lt, l_ul, l_tk;
  logic [GH_W-1:0] l_gh;
  logic [LH_W-1:0] l_lh;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < (1 << GH_W); i++) m_g[i] = 2'd1;
    for (int i = 0; i < (1 << LH_W); i++) m_l[i] = 3'd3;
    for (int i = 0; i < (1 << IDX_W); i++) m_ch[i] = 2'd1;
    for (int i = 0; i < (1 << LT_W); i++) m_lht[i] = '0;
    m_ghr = '0;
  endtask

  function automatic exp_t model_predict(input logic [IDX_W-1:0] a);
    exp_t e;
    e.gh = m_ghr;
    e.lh = m_lht[a[LT_W-1:0]];
    e.gt = m_g[e.gh][1];
    e.lt = m_l[e.lh][2];
    e.ul = m_ch[a][1];
    e.tk = e.ul ? e.lt : e.gt;
    return e;
  endfunction

  task automatic model_update(input logic [IDX_W-1:0] a, input logic tk,
                              input logic [GH_W-1:0] gh, input logic [LH_W-1:0] lh,
                              input logic gt, input logic lt);
    if (tk && m_g[gh] != 3) m_g[gh]++;
    else if (!tk && m_g[gh] != 0) m_g[gh]--;
    if (tk && m_l[lh] != 7) m_l[lh]++;
    else if (!tk && m_l[lh] != 0) m_l[lh]--;
    if ((lt == tk) && (gt != tk) && m_ch[a] != 3) m_ch[a]++;
    else if ((gt == tk) && (lt != tk) && m_ch[a] != 0) m_ch[a]--;
    m_lht[a[LT_W-1:0]] = {m_lht[a[LT_W-1:0]][LH_W-2:0], tk};
    m_ghr = {m_ghr[GH_W-2:0], tk};
  endtask

  // monitor: pops expected items and compares
  always @(negedge clk) begin
    if (!rst && pred_valid) begin
      if (q.size() == 0) begin
        chk(0, "R2 unexpected pred_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(pred_taken == e.tk, "R11 pred_taken", pred_taken, e.tk);
        chk(pred_use_local == e.ul, "R7 pred_use_local", pred_use_local, e.ul);
        chk(pred_gtaken == e.gt, "R3 pred_gtaken", pred_gtaken, e.gt);
        chk(pred_ltaken == e.lt, "R6 pred_ltaken", pred_ltaken, e.lt);
        chk(pred_ghist == e.gh, "R4 pred_ghist", pred_ghist, e.gh);
        chk(pred_lhist == e.lh, "R5 pred_lhist", pred_lhist, e.lh);
      end
      l_gt = pred_gtaken; l_lt = pred_ltaken; l_ul = pred_use_local;
      l_tk = pred_taken; l_gh = pred_ghist; l_lh = pred_lhist;
    end
  end

  task automatic do_lookup(input logic [IDX_W-1:0] a);
    @(negedge clk);
    lookup_valid = 1; lookup_idx = a;
    q.push_back(model_predict(a));
    @(negedge clk);
    lookup_valid = 0;
    #1;
  endtask

  task automatic do_update(input logic [IDX_W-1:0] a, input logic tk,
                           input logic [GH_W-1:0] gh, input logic [LH_W-1:0] lh,
                           input logic gt, input logic lt);
    @(negedge clk);
    upd_valid = 1; upd_idx = a; upd_taken = tk;
    upd_ghist = gh; upd_lhist = lh; upd_gtaken = gt; upd_ltaken = lt;
    model_update(a, tk, gh, lh, gt, lt);
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic predict_resolve(input logic [IDX_W-1:0] a, input logic tk);
    do_lookup(a);
    do_update(a, tk, l_gh, l_lh, l_gt, l_lt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [GH_W-1:0] s_gh;
    logic [LH_W-1:0] s_lh;
    logic s_gt, s_lt;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: nothing valid after reset
    @(negedge clk);
    chk(pred_valid == 0, "R1 pred_valid after reset", pred_valid, 0);

    // R1: first lookup shows weak not-taken, global chosen, zero histories
    do_lookup(6'd5);
    chk(l_tk == 0 && l_ul == 0, "R1 reset prediction", {l_tk, l_ul}, 0);
    chk(l_gh == 0 && l_lh == 0, "R1 reset histories", {l_gh, l_lh}, 0);

    // R8: only local right -> chooser 1->2, local selected
    do_update(6'd9, 1, '0, '0, 0, 1);
    do_lookup(6'd9);
    chk(l_ul == 1, "R8 chooser moved to local", l_ul, 1);
    // R9: both right and both wrong leave the chooser alone
    do_update(6'd9, 1, 6'd3, 6'd2, 1, 1);
    do_update(6'd9, 0, 6'd3, 6'd2, 1, 1);
    do_update(6'd9, 1, 6'd4, 6'd1, 1, 1);
    do_lookup(6'd9);
    chk(l_ul == 1, "R9 chooser held on agreement", l_ul, 1);
    // R8: only global right -> back to global
    do_update(6'd9, 0, 6'd7, 6'd7, 0, 1);
    do_lookup(6'd9);
    chk(l_ul == 0, "R8 chooser moved to global", l_ul, 0);
    // R8: saturation at 3, then one step down still local
    for (int i = 0; i < 6; i++) do_update(6'd9, 1, 6'd8, 6'd9, 0, 1);
    do_update(6'd9, 1, 6'd8, 6'd9, 1, 0);
    do_lookup(6'd9);
    chk(l_ul == 1, "R8 chooser saturated high", l_ul, 1);
    // R8: floor at 0, then one step up still global
    for (int i = 0; i < 6; i++) do_update(6'd9, 0, 6'd8, 6'd9, 0, 1);
    do_update(6'd9, 0, 6'd8, 6'd9, 1, 0);
    do_lookup(6'd9);
    chk(l_ul == 0, "R8 chooser saturated low", l_ul, 0);

    // R10: stale metadata returned after other updates
    do_lookup(6'd4);
    s_gh = l_gh; s_lh = l_lh; s_gt = l_gt; s_lt = l_lt;
    predict_resolve(6'd20, 1);
    predict_resolve(6'd21, 0);
    predict_resolve(6'd22, 1);
    do_update(6'd4, 1, s_gh, s_lh, s_gt, s_lt);
    for (int i = 0; i < 8; i++) predict_resolve(6'(4 + 16 * (i % 2)), 1);

    // R2: lookup and update on the same edge; lookup sees old state
    @(negedge clk);
    lookup_valid = 1; lookup_idx = 6'd33;
    q.push_back(model_predict(6'd33));
    upd_valid = 1; upd_idx = 6'd33; upd_taken = 1;
    upd_ghist = m_ghr; upd_lhist = m_lht[1]; upd_gtaken = 0; upd_ltaken = 1;
    model_update(6'd33, 1, upd_ghist, upd_lhist, 0, 1);
    @(negedge clk);
    lookup_valid = 0; upd_valid = 0;
    #1;
    do_lookup(6'd33);

    // R3 R6: long biased runs push counters into both limits
    for (int i = 0; i < 12; i++) predict_resolve(6'd12, 1);
    for (int i = 0; i < 12; i++) predict_resolve(6'd12, 0);
    for (int i = 0; i < 20; i++) predict_resolve(6'd40, i[0]);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [IDX_W-1:0] a;
      a = 6'($urandom % 64);
      predict_resolve(a, (($urandom % 4) != 0) ^ a[1]);
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 all lookups answered", q.size(), 0);
    finish_run();
  end
endmodule